// File: doc/BRIEF.md
# Snooping Write-Through Cache Controller

This block is the private cache of one processor on a shared, snooped bus. It is direct-mapped, keeps one data word per line and gives each line one of two states: Valid or Invalid. Every processor write goes through to the bus. Writes never allocate a line. A write that misses leaves the cache untouched. A write that hits refreshes the local word and keeps the line Valid. A read that hits is answered from the local array. A read that misses fetches the word over the bus and fills the line.

The controller snoops every transaction that appears on the bus. A write issued by another agent to an address held Valid here clears that line. Bus reads from other agents change nothing. The controller recognises its own transactions by a requester ID and ignores them. A fill that races with a remote write to the same address still returns data to the processor, but the filled line is left Invalid so that stale data cannot be hit later.

Top module: `snoop_wt_cache`

## Requirements
- R1: After the asynchronous reset, every line is Invalid, `cpu_ready_o` is 1, and `cpu_done_o` and `bus_req_o` are 0. The first read of any address therefore goes to the bus.
- R2: A read that misses raises `bus_req_o` with `bus_op_o` = 1 (read) and the request address. When `bus_ack_i` arrives, `cpu_done_o` pulses with `bus_rdata_i` on `cpu_rdata_o`, and the line becomes Valid.
- R3: A read that hits raises `cpu_done_o` one cycle after it is accepted, with the local word on `cpu_rdata_o` and no bus request.
- R4: Every accepted write raises `bus_req_o` with `bus_op_o` = 2 (write), its address and its data, whatever the line's state. `cpu_done_o` pulses after `bus_ack_i`.
- R5: A write that misses fetches nothing and leaves the line Invalid, so a later read of that address misses.
- R6: A write that hits updates the local word and keeps the line Valid, so a later read hits and returns the written value.
- R7: A snooped bus write (`snp_op_i` = 2) from another requester invalidates the local line only when both index and tag match a Valid line.
- R8: A snooped bus read (`snp_op_i` = 1) from another requester changes no line state.
- R9: A snooped transaction whose `snp_id_i` equals the controller's own ID changes no line state.
- R10: A remote write to the address of a pending read fill leaves the filled line Invalid, while the read still completes with the bus data. This holds when the write is seen between grant and acknowledge, and when it is seen in the acknowledge cycle.
- R11: `bus_req_o` and its op, address and data stay stable until `bus_gnt_i`. `cpu_ready_o` is 0 from acceptance until completion.
- R12: The low `IDX_W` address bits select the line and the remaining bits form the tag. A read of a different tag at the same index misses and replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, taken when `cpu_ready_o` is 1 |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Controller idle, can take a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with `cpu_done_o` |
| bus_req_o | output | 1 | Bus request, held until grant |
| bus_gnt_i | input | 1 | Bus grant |
| bus_op_o | output | 2 | 0 idle, 1 read, 2 write |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Transaction write data |
| bus_id_o | output | ID_W | Own requester ID |
| bus_ack_i | input | 1 | Transaction complete |
| bus_rdata_i | input | DATA_W | Read data, valid with `bus_ack_i` |
| snp_valid_i | input | 1 | A bus transaction is visible this cycle |
| snp_op_i | input | 2 | Op of the observed transaction |
| snp_addr_i | input | ADDR_W | Address of the observed transaction |
| snp_id_i | input | ID_W | Requester of the observed transaction |

## Verification
The bench acts as both the bus agent and the other processors, and keeps its own copy of memory and of line state. It aims at the races between a fill and a remote write, both in the wait window and in the acknowledge cycle. A controller that ignored these would later serve a stale word on a hit. It also exercises write misses, where a design that allocated would hit on the next read and skip the bus. It covers own-ID and remote-read snoops, where a careless filter would drop lines and cause needless misses. Finally it checks same-index, different-tag writes, where a design that matched the index alone would invalidate the wrong line.

// File: rtl/swt_pkg.sv
package swt_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RD   = 2'd1,
    BUS_WR   = 2'd2
  } bus_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } ctl_st_e;
endpackage

// File: rtl/swt_tag_store.sv
module swt_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             sn_en_i,
  input  logic [IDX_W-1:0] sn_idx_i,
  input  logic [TAG_W-1:0] sn_tag_i,
  output logic             sn_hit_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i,
  input  logic             fill_valid_i
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  assign lk_hit_o = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign sn_hit_o = sn_en_i && valid_q[sn_idx_i] && (tag_q[sn_idx_i] == sn_tag_i);

  // fill wins over a same-cycle snoop on the same index
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_comb begin
      valid_d[g] = valid_q[g];
      if (fill_en_i && fill_idx_i == IDX_W'(g))
        valid_d[g] = fill_valid_i;
      else if (sn_hit_o && sn_idx_i == IDX_W'(g))
        valid_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) tag_q[fill_idx_i] <= fill_tag_i;
  end
endmodule

// File: rtl/swt_data_store.sv
module swt_data_store #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int LINES = 1 << IDX_W;

  logic [DATA_W-1:0] word_q [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) word_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = word_q[rd_idx_i];
endmodule

// File: rtl/swt_snoop_filter.sv
module swt_snoop_filter #(
  parameter int ID_W  = 2,
  parameter int MY_ID = 0
) (
  input  logic            snp_valid_i,
  input  logic [1:0]      snp_op_i,
  input  logic [ID_W-1:0] snp_id_i,
  output logic            remote_wr_o
);
  import swt_pkg::*;

  assign remote_wr_o = snp_valid_i && (bus_op_e'(snp_op_i) == BUS_WR) &&
                       (snp_id_i != ID_W'(MY_ID));
endmodule

// File: rtl/swt_ctl.sv
module swt_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [ID_W-1:0]   bus_id_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              remote_wr_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic [DATA_W-1:0] line_data_i,
  output logic              fill_en_o,
  output logic              fill_valid_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import swt_pkg::*;

  ctl_st_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              we_q, stale_q, done_q;
  logic              snp_same, finish;

  assign snp_same    = remote_wr_i && (snp_addr_i == addr_q);
  assign finish      = (st_q == ST_WAIT) && bus_ack_i;
  assign lk_addr_o   = (st_q == ST_IDLE) ? cpu_addr_i : addr_q;

  assign cpu_ready_o = (st_q == ST_IDLE);
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;

  assign bus_req_o   = (st_q == ST_REQ);
  assign bus_op_o    = (st_q == ST_REQ) ? (we_q ? BUS_WR : BUS_RD) : BUS_IDLE;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign bus_id_o    = ID_W'(MY_ID);

  // a remote write seen after our grant means the fetched word may be old
  assign fill_en_o    = finish && !we_q;
  assign fill_valid_o = !(stale_q || snp_same);
  assign wr_en_o      = fill_en_o || (finish && we_q && lk_hit_i);
  assign wr_data_o    = we_q ? wdata_q : bus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      we_q    <= 1'b0;
      stale_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cpu_req_i) begin
            if (!cpu_we_i && lk_hit_i) begin
              done_q  <= 1'b1;
              rdata_q <= line_data_i;
            end else begin
              st_q    <= ST_REQ;
              addr_q  <= cpu_addr_i;
              wdata_q <= cpu_wdata_i;
              we_q    <= cpu_we_i;
            end
          end
        end
        ST_REQ: begin
          if (bus_gnt_i) begin
            st_q    <= ST_WAIT;
            stale_q <= 1'b0;
          end
        end
        ST_WAIT: begin
          if (snp_same) stale_q <= 1'b1;
          if (bus_ack_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            if (!we_q) rdata_q <= bus_rdata_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_wt_cache.sv
module snoop_wt_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [ID_W-1:0]   bus_id_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [ID_W-1:0]   snp_id_i
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              remote_wr;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit, fill_en, fill_valid, wr_en;
  logic [DATA_W-1:0] line_data, wr_data;

  swt_snoop_filter #(.ID_W(ID_W), .MY_ID(MY_ID)) u_filt (
    .snp_valid_i (snp_valid_i),
    .snp_op_i    (snp_op_i),
    .snp_id_i    (snp_id_i),
    .remote_wr_o (remote_wr)
  );

  swt_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lk_idx_i     (lk_addr[IDX_W-1:0]),
    .lk_tag_i     (lk_addr[ADDR_W-1:IDX_W]),
    .lk_hit_o     (lk_hit),
    .sn_en_i      (remote_wr),
    .sn_idx_i     (snp_addr_i[IDX_W-1:0]),
    .sn_tag_i     (snp_addr_i[ADDR_W-1:IDX_W]),
    .sn_hit_o     (),
    .fill_en_i    (fill_en),
    .fill_idx_i   (lk_addr[IDX_W-1:0]),
    .fill_tag_i   (lk_addr[ADDR_W-1:IDX_W]),
    .fill_valid_i (fill_valid)
  );

  swt_data_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_idx_i  (lk_addr[IDX_W-1:0]),
    .wr_data_i (wr_data),
    .rd_idx_i  (lk_addr[IDX_W-1:0]),
    .rd_data_o (line_data)
  );

  swt_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_req_i    (cpu_req_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .cpu_ready_o  (cpu_ready_o),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .bus_req_o    (bus_req_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_op_o     (bus_op_o),
    .bus_addr_o   (bus_addr_o),
    .bus_wdata_o  (bus_wdata_o),
    .bus_id_o     (bus_id_o),
    .bus_ack_i    (bus_ack_i),
    .bus_rdata_i  (bus_rdata_i),
    .remote_wr_i  (remote_wr),
    .snp_addr_i   (snp_addr_i),
    .lk_addr_o    (lk_addr),
    .lk_hit_i     (lk_hit),
    .line_data_i  (line_data),
    .fill_en_o    (fill_en),
    .fill_valid_o (fill_valid),
    .wr_en_o      (wr_en),
    .wr_data_o    (wr_data)
  );
endmodule

// File: rtl/swt_cache_chk.sv
module swt_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic              cpu_ready_o,
  input logic              cpu_done_o,
  input logic              bus_req_o,
  input logic              bus_gnt_i,
  input logic [1:0]        bus_op_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o
);
  AST_WRITE_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && cpu_req_i && cpu_we_i |=> bus_req_o && bus_op_o == 2'd2); // R4

  AST_READ_HIT_OR_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ready_o && cpu_req_i && !cpu_we_i |=> cpu_done_o != bus_req_o); // R2

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_op_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o)); // R11

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cpu_ready_o); // R11

  AST_DONE_RETURNS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> cpu_ready_o && !bus_req_o); // R3
endmodule

bind snoop_wt_cache swt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/snoop_wt_cache_tb.sv
module snoop_wt_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int IW = 3;
  localparam int DW = 32;
  localparam int IDW = 2;
  localparam int MYID = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic bus_req, bus_gnt = 0, bus_ack = 0;
  logic [1:0] bus_op;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic [IDW-1:0] bus_id;
  logic snp_valid = 0;
  logic [1:0] snp_op = 0;
  logic [AW-1:0] snp_addr = '0;
  logic [IDW-1:0] snp_id = '0;

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] mem [1<<AW];
  logic [(1<<IW)-1:0] ref_v = '0;
  logic [AW-IW-1:0] ref_t [1<<IW];

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_wt_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .ID_W(IDW), .MY_ID(MYID)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready), .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_op_o(bus_op), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_id_o(bus_id), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr), .snp_id_i(snp_id)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %h exp %h", rq, what, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [AW-1:0] a);
    return ref_v[a[IW-1:0]] && ref_t[a[IW-1:0]] == a[AW-1:IW];
  endfunction

  function automatic logic [IDW-1:0] remote_id();
    return IDW'((MYID + 1 + int'($urandom % 3)) % 4);
  endfunction

  // remote write updates memory and the reference line state
  task automatic apply_remote(input logic [1:0] op, input logic [IDW-1:0] id,
                              input logic [AW-1:0] a, input logic [DW-1:0] d);
    if (op == 2'd2 && id != IDW'(MYID)) begin
      mem[a] = d;
      if (ref_hit(a)) ref_v[a[IW-1:0]] = 1'b0;
    end
  endtask

  task automatic snoop(input logic [1:0] op, input logic [IDW-1:0] id,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_op = op; snp_id = id; snp_addr = a;
    apply_remote(op, id, a, d);
    @(negedge clk);
    snp_valid = 0;
  endtask

  // inj: 0 none, 1 remote write in wait window, 2 remote write in ack cycle
  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int inj, input string rq);
    bit exp_bus;
    logic [DW-1:0] rd_val;
    exp_bus = we || !ref_hit(a);
    @(negedge clk);
    chk(cpu_done == 0, "R3", "done idle low", DW'(cpu_done), 0);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0;
    chk((bus_req && !cpu_done) == exp_bus, rq, "bus used", DW'(bus_req), DW'(exp_bus));
    if (cpu_done) begin
      chk(cpu_rdata == mem[a], rq, "hit data", cpu_rdata, mem[a]);
    end else begin
      chk(bus_op == (we ? 2'd2 : 2'd1) && bus_addr == a, we ? "R4" : "R2", "bus op/addr",
          DW'({bus_op, bus_addr}), DW'({(we ? 2'd2 : 2'd1), a}));
      if (we) chk(bus_wdata == d, "R4", "bus wdata", bus_wdata, d);
      repeat (int'($urandom % 3)) @(negedge clk);
      chk(bus_req && !cpu_ready && bus_addr == a, "R11", "request held", DW'(bus_addr), DW'(a));
      bus_gnt = 1;
      rd_val = mem[a];
      @(negedge clk);
      bus_gnt = 0;
      if (inj == 1) begin
        snp_valid = 1; snp_op = 2'd2; snp_id = remote_id(); snp_addr = a;
        apply_remote(2'd2, snp_id, a, $urandom);
        @(negedge clk);
        snp_valid = 0;
      end
      repeat (int'($urandom % 2)) @(negedge clk);
      bus_ack = 1; bus_rdata = rd_val;
      if (we) mem[a] = d;
      if (inj == 2) begin
        snp_valid = 1; snp_op = 2'd2; snp_id = remote_id(); snp_addr = a;
        apply_remote(2'd2, snp_id, a, $urandom);
      end
      @(negedge clk);
      bus_ack = 0; snp_valid = 0;
      chk(cpu_done == 1, we ? "R4" : "R2", "done after ack", DW'(cpu_done), 1);
      if (!we) begin
        chk(cpu_rdata == rd_val, inj != 0 ? "R10" : "R2", "fill data", cpu_rdata, rd_val);
        ref_v[a[IW-1:0]] = (inj == 0);
        ref_t[a[IW-1:0]] = a[AW-1:IW];
      end
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    return AW'((($urandom % 4) << IW) | ($urandom % 4));
  endfunction

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = $urandom(32'h5a17);
    repeat (3) @(negedge clk);
    chk(cpu_ready == 1 && cpu_done == 0 && bus_req == 0, "R1", "reset outputs",
        DW'({cpu_ready, cpu_done, bus_req}), 32'h4);
    rst_n = 1;

    cpu_op(0, 8'h0A, 0, 0, "R1");          // first read misses
    cpu_op(0, 8'h0A, 0, 0, "R3");          // hit
    cpu_op(1, 8'h0A, 32'hCAFE0001, 0, "R4"); // write hit through
    cpu_op(0, 8'h0A, 0, 0, "R6");          // hit with new word
    cpu_op(1, 8'h13, 32'hBEEF0002, 0, "R4"); // write miss
    cpu_op(0, 8'h13, 0, 0, "R5");          // still a miss
    snoop(2'd2, IDW'(2), 8'h0A, 32'h11112222);
    cpu_op(0, 8'h0A, 0, 0, "R7");          // invalidated: miss, new data
    snoop(2'd1, IDW'(3), 8'h0A, 0);
    cpu_op(0, 8'h0A, 0, 0, "R8");          // remote read: still hit
    snoop(2'd2, IDW'(MYID), 8'h0A, 0);
    cpu_op(0, 8'h0A, 0, 0, "R9");          // own id ignored
    snoop(2'd2, IDW'(0), 8'h12, 32'h33334444);
    cpu_op(0, 8'h0A, 0, 0, "R7");          // same index other tag: hit
    cpu_op(0, 8'h12, 0, 0, "R12");         // conflict miss
    cpu_op(0, 8'h0A, 0, 0, "R12");         // evicted: miss
    cpu_op(0, 8'h21, 0, 1, "R10");         // race in wait window
    cpu_op(0, 8'h21, 0, 0, "R10");         // must miss
    cpu_op(0, 8'h22, 0, 2, "R10");         // race in ack cycle
    cpu_op(0, 8'h22, 0, 0, "R10");         // must miss

    for (int n = 0; n < 400; n++) begin
      int k;
      logic [AW-1:0] a;
      k = int'($urandom % 10);
      a = pick_addr();
      if (k < 4)       cpu_op(0, a, 0, 0, "R3");
      else if (k < 6)  cpu_op(1, a, $urandom, 0, "R6");
      else if (k == 6) cpu_op(0, a, 0, 1 + int'($urandom % 2), "R10");
      else if (k == 7) snoop(2'd2, remote_id(), a, $urandom);
      else if (k == 8) snoop(2'd1, remote_id(), a, 0);
      else             snoop(2'd2, IDW'(MYID), a, 0);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule